// File: doc/BRIEF.md
# Compare and Test Flag Unit

This unit evaluates the condition-setting instructions of a 32-bit RISC integer core and keeps the three one-bit flags that those instructions write. One flag is the condition flag T. The other two, M and Q, are the divide-step flags. On every clock edge where the strobe is high, the unit takes two operands and an operation code. It works out the new flag values from them and stores the result in its flag registers. An immediate of IMM_W bits can be sign-extended and used in place of the second operand.

The operations fall into several groups:
- Equality, signed and unsigned ordering compares.
- A compare that is true when any byte lane of the two operands matches.
- A bitwise test for an all-zero AND.
- Sign tests on one operand.
- A decrement that also tests the result for zero. It returns the decremented register value on a combinational output.
- The two divide-setup operations.
- Direct set and clear of T.

The divide iteration itself, the multiply-accumulate path and the register file are outside this unit.

Top module: `cmp_test_flag_unit`

## Requirements
- R1: While `rst_n` is low, T, M and Q are all 0, and they stay 0 at the first edge after release.
- R2: At a clock edge, T, M and Q keep their values when `strobe` is low or when `op` is a reserved code (14 or 15). M and Q change only for op codes 10 and 11.
- R3: Op 0 (equal) sets T to 1 exactly when the second operand equals `opnd_a`. When `use_imm` is 1, the second operand for every operation is the sign-extended `imm` in place of `opnd_b`.
- R4: Op 1 sets T when the second operand is greater than or equal to `opnd_a`, both taken as unsigned. Op 2 applies the same rule with both taken as two's-complement signed.
- R5: Op 3 (unsigned) and op 4 (signed) set T only when the second operand is strictly greater than `opnd_a`.
- R6: Op 5 sets T when at least one of the four byte lanes (bits 7:0, 15:8, 23:16, 31:24) holds the same value in both operands.
- R7: Op 6 sets T when the bitwise AND of `opnd_a` and the second operand is zero. This includes the sign-extended immediate case.
- R8: Op 7 sets T when `opnd_a` is signed greater than zero. Op 8 sets T when `opnd_a` is signed greater than or equal to zero.
- R9: With op 9 and `strobe` high, `dec_out` is `opnd_a` minus one, wrapping modulo 2^32. T is set when that result is zero.
- R10: Op 10 (signed divide setup) loads Q with bit 31 of the second operand (the dividend) and M with bit 31 of `opnd_a` (the divisor). It sets T to the XOR of those two bits.
- R11: Op 11 (unsigned divide setup) clears M, Q and T.
- R12: Op 12 forces T to 1 and op 13 forces T to 0. Neither changes M or Q.
- R13: `dec_out` equals `opnd_a` unchanged whenever `strobe` is low or `op` is not 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe | input | 1 | Perform the selected operation at this edge |
| op | input | 4 | Operation code, values as in the requirements |
| use_imm | input | 1 | Use the sign-extended immediate in place of `opnd_b` |
| opnd_a | input | 32 | First operand / decremented register / divisor |
| opnd_b | input | 32 | Second operand / dividend |
| imm | input | 8 | Immediate, sign-extended to 32 bits |
| dec_out | output | 32 | Decremented value for op 9, otherwise `opnd_a` |
| flag_t | output | 1 | Registered condition flag T |
| flag_m | output | 1 | Registered divide flag M |
| flag_q | output | 1 | Registered divide flag Q |

## Verification
The bench uses operand pairs whose signed and unsigned orderings disagree, such as 1 against all-ones. A design that mixed up signedness, or swapped which operand is compared against which, would give the wrong T. It drives a byte-lane compare where only one middle lane matches, and one where no lane matches. This catches a lane that is left out or an AND used in place of an OR. It decrements from 1 and from 0 to test both the zero detection and the wrap. It drives idle cycles with changing operands, which expose flags that change without a strobe or a `dec_out` that does not pass the operand through. It also checks the sign-extended immediate, which a zero-extending design would get wrong.

// File: rtl/cmpflag_pkg.sv
package cmpflag_pkg;

    typedef enum logic [3:0] {
        CF_EQ    = 4'd0,
        CF_HS    = 4'd1,
        CF_GE    = 4'd2,
        CF_HI    = 4'd3,
        CF_GT    = 4'd4,
        CF_STR   = 4'd5,
        CF_TST   = 4'd6,
        CF_PL    = 4'd7,
        CF_PZ    = 4'd8,
        CF_DT    = 4'd9,
        CF_DIVS  = 4'd10,
        CF_DIVU  = 4'd11,
        CF_SETT  = 4'd12,
        CF_CLRT  = 4'd13
    } cf_op_e;

    typedef struct packed {
        logic t_val;
        logic m_val;
        logic q_val;
        logic t_we;
        logic mq_we;
    } cf_upd_s;

endpackage

// File: rtl/cf_lane_match.sv
module cf_lane_match #(
    parameter int W      = 32,
    parameter int LANE_W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic         any_eq
);
    localparam int LANES = W / LANE_W;

    logic [LANES-1:0] lane_hit;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_hit[g] = (x[g*LANE_W +: LANE_W] == y[g*LANE_W +: LANE_W]);
    end

    assign any_eq = |lane_hit;
endmodule

// File: rtl/cf_eval.sv
module cf_eval
    import cmpflag_pkg::*;
#(
    parameter int W = 32
) (
    input  cf_op_e       op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] dec,
    output cf_upd_s      upd
);
    logic any_eq;

    cf_lane_match #(.W(W), .LANE_W(8)) u_lane (
        .x      (a),
        .y      (b),
        .any_eq (any_eq)
    );

    assign dec = a - {{(W-1){1'b0}}, 1'b1};

    always_comb begin
        upd = '0;
        unique case (op)
            CF_EQ:   begin upd.t_we = 1'b1; upd.t_val = (b == a); end
            CF_HS:   begin upd.t_we = 1'b1; upd.t_val = (b >= a); end
            CF_GE:   begin upd.t_we = 1'b1; upd.t_val = ($signed(b) >= $signed(a)); end
            CF_HI:   begin upd.t_we = 1'b1; upd.t_val = (b > a); end
            CF_GT:   begin upd.t_we = 1'b1; upd.t_val = ($signed(b) > $signed(a)); end
            CF_STR:  begin upd.t_we = 1'b1; upd.t_val = any_eq; end
            CF_TST:  begin upd.t_we = 1'b1; upd.t_val = ((a & b) == '0); end
            CF_PL:   begin upd.t_we = 1'b1; upd.t_val = ($signed(a) > 0); end
            CF_PZ:   begin upd.t_we = 1'b1; upd.t_val = ~a[W-1]; end
            CF_DT:   begin upd.t_we = 1'b1; upd.t_val = (dec == '0); end
            CF_DIVS: begin
                upd.t_we  = 1'b1;
                upd.mq_we = 1'b1;
                upd.q_val = b[W-1];
                upd.m_val = a[W-1];
                upd.t_val = b[W-1] ^ a[W-1];
            end
            CF_DIVU: begin upd.t_we = 1'b1; upd.mq_we = 1'b1; end
            CF_SETT: begin upd.t_we = 1'b1; upd.t_val = 1'b1; end
            CF_CLRT: begin upd.t_we = 1'b1; upd.t_val = 1'b0; end
            default: upd = '0;
        endcase
    end
endmodule

// File: rtl/cf_flag_reg.sv
module cf_flag_reg
    import cmpflag_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    strobe,
    input  cf_upd_s upd,
    output logic    t_q,
    output logic    m_q,
    output logic    q_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= 1'b0;
            m_q <= 1'b0;
            q_q <= 1'b0;
        end else if (strobe) begin
            if (upd.t_we) t_q <= upd.t_val;
            if (upd.mq_we) begin
                m_q <= upd.m_val;
                q_q <= upd.q_val;
            end
        end
    end

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(t_q) && $stable(m_q) && $stable(q_q)));

    // R2
    mq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(strobe && upd.mq_we) |=> ($stable(m_q) && $stable(q_q)));
endmodule

// File: rtl/cmp_test_flag_unit.sv
module cmp_test_flag_unit
    import cmpflag_pkg::*;
#(
    parameter int W     = 32,
    parameter int IMM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [3:0]       op,
    input  logic             use_imm,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [IMM_W-1:0] imm,
    output logic [W-1:0]     dec_out,
    output logic             flag_t,
    output logic             flag_m,
    output logic             flag_q
);
    localparam int EXT_W = W - IMM_W;

    cf_op_e       op_e;
    logic [W-1:0] b_sel;
    logic [W-1:0] dec_val;
    cf_upd_s      upd;

    assign op_e  = cf_op_e'(op);
    assign b_sel = use_imm ? {{EXT_W{imm[IMM_W-1]}}, imm} : opnd_b;

    cf_eval #(.W(W)) u_eval (
        .op  (op_e),
        .a   (opnd_a),
        .b   (b_sel),
        .dec (dec_val),
        .upd (upd)
    );

    cf_flag_reg u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .upd    (upd),
        .t_q    (flag_t),
        .m_q    (flag_m),
        .q_q    (flag_q)
    );

    assign dec_out = (strobe && op_e == CF_DT) ? dec_val : opnd_a;

    // R13
    dec_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |-> (dec_out == opnd_a));

    // R12
    sett_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op == 4'd12) |=> (flag_t && $stable(flag_m) && $stable(flag_q)));

    // R12
    clrt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op == 4'd13) |=> (!flag_t && $stable(flag_m) && $stable(flag_q)));

    // R11
    divu_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op == 4'd11) |=> (!flag_t && !flag_m && !flag_q));

    // R10
    divs_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && op == 4'd10) |=> (flag_t == (flag_m ^ flag_q)));

    // R2
    reserved_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op[3:1] == 3'b111) |=> ($stable(flag_t) && $stable(flag_m) && $stable(flag_q)));
endmodule

// File: tb/tb_cmp_test_flag_unit.sv
`timescale 1ns/1ps
module tb_cmp_test_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strobe = 1'b0;
    logic [3:0]  op = 4'd0;
    logic        use_imm = 1'b0;
    logic [31:0] opnd_a = '0;
    logic [31:0] opnd_b = '0;
    logic [7:0]  imm = '0;
    logic [31:0] dec_out;
    logic        flag_t, flag_m, flag_q;

    int checks = 0;
    int fails  = 0;
    logic mt = 1'b0, mm = 1'b0, mqf = 1'b0;
    logic [2:0] exp_fifo[$];
    string      tag_fifo[$];

    always #2 clk = ~clk;

    cmp_test_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .op(op), .use_imm(use_imm),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm), .dec_out(dec_out),
        .flag_t(flag_t), .flag_m(flag_m), .flag_q(flag_q)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: compare registered flags one step after each driven edge
    always @(posedge clk) begin
        #1;
        if (exp_fifo.size() > 0) begin
            logic [2:0] e;
            string tg;
            e  = exp_fifo.pop_front();
            tg = tag_fifo.pop_front();
            check(tg, {29'd0, flag_t, flag_m, flag_q}, {29'd0, e});
        end
    end

    function automatic logic ge_s(logic [31:0] x, logic [31:0] y);
        return {~x[31], x[30:0]} >= {~y[31], y[30:0]};
    endfunction

    task automatic drive(string tag, logic stb, logic [3:0] o, logic [31:0] a,
                         logic [31:0] b, logic ui, logic [7:0] im);
        logic [31:0] sb;
        logic [31:0] dexp;
        @(negedge clk);
        strobe = stb; op = o; opnd_a = a; opnd_b = b; use_imm = ui; imm = im;
        sb   = ui ? {{24{im[7]}}, im} : b;
        dexp = (stb && o == 4'd9) ? a + 32'hFFFF_FFFF : a;
        #1;
        check((stb && o == 4'd9) ? "R9 dec" : "R13 pass", dec_out, dexp);
        if (stb) begin
            case (o)
                4'd0:  mt = (sb == a);
                4'd1:  mt = ({1'b0, sb} >= {1'b0, a});
                4'd2:  mt = ge_s(sb, a);
                4'd3:  mt = ({1'b0, sb} > {1'b0, a});
                4'd4:  mt = ge_s(sb, a) && (sb != a);
                4'd5:  mt = (sb[7:0] == a[7:0]) || (sb[15:8] == a[15:8]) ||
                            (sb[23:16] == a[23:16]) || (sb[31:24] == a[31:24]);
                4'd6:  mt = ~|(a & sb);
                4'd7:  mt = !a[31] && (a != 0);
                4'd8:  mt = !a[31];
                4'd9:  mt = (a == 32'd1);
                4'd10: begin mqf = sb[31]; mm = a[31]; mt = sb[31] ^ a[31]; end
                4'd11: begin mqf = 1'b0; mm = 1'b0; mt = 1'b0; end
                4'd12: mt = 1'b1;
                4'd13: mt = 1'b0;
                default: ;
            endcase
        end
        exp_fifo.push_back({mt, mm, mqf});
        tag_fifo.push_back(tag);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {29'd0, flag_t, flag_m, flag_q}, 32'd0);
        rst_n = 1'b1;
        drive("R1 after release", 1'b0, 4'd12, 32'h5, 32'h6, 1'b0, 8'h0);

        drive("R12 set T",   1'b1, 4'd12, 32'h0, 32'h0, 1'b0, 8'h0);
        drive("R2 idle hold", 1'b0, 4'd13, 32'hDEAD_BEEF, 32'h0, 1'b0, 8'h0);
        drive("R12 clear T", 1'b1, 4'd13, 32'h0, 32'h0, 1'b0, 8'h0);

        drive("R3 eq true",   1'b1, 4'd0, 32'h1234_5678, 32'h1234_5678, 1'b0, 8'h0);
        drive("R3 eq false",  1'b1, 4'd0, 32'h1234_5678, 32'h1234_5679, 1'b0, 8'h0);
        drive("R3 eq imm sx", 1'b1, 4'd0, 32'hFFFF_FFFF, 32'h0, 1'b1, 8'hFF);

        drive("R4 hs uns",   1'b1, 4'd1, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 8'h0);
        drive("R4 ge sgn",   1'b1, 4'd2, 32'h0000_0001, 32'hFFFF_FFFF, 1'b0, 8'h0);
        drive("R4 hs equal", 1'b1, 4'd1, 32'h0000_0040, 32'h0000_0040, 1'b0, 8'h0);
        drive("R4 ge equal", 1'b1, 4'd2, 32'h8000_0000, 32'h8000_0000, 1'b0, 8'h0);
        drive("R5 hi equal", 1'b1, 4'd3, 32'h0000_0040, 32'h0000_0040, 1'b0, 8'h0);
        drive("R5 gt equal", 1'b1, 4'd4, 32'h0000_0040, 32'h0000_0040, 1'b0, 8'h0);
        drive("R5 hi uns",   1'b1, 4'd3, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 8'h0);
        drive("R5 gt sgn",   1'b1, 4'd4, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 8'h0);
        drive("R5 gt neg",   1'b1, 4'd4, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 1'b0, 8'h0);

        drive("R6 one lane", 1'b1, 4'd5, 32'h1234_5678, 32'hAA34_BBCC, 1'b0, 8'h0);
        drive("R6 no lane",  1'b1, 4'd5, 32'h1234_5678, 32'h8765_4321, 1'b0, 8'h0);
        drive("R6 top lane", 1'b1, 4'd5, 32'h9900_0000, 32'h99FF_FFFF, 1'b0, 8'h0);

        drive("R7 tst zero",  1'b1, 4'd6, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 1'b0, 8'h0);
        drive("R7 tst hit",   1'b1, 4'd6, 32'h0000_0100, 32'h0000_0300, 1'b0, 8'h0);
        drive("R7 tst imm",   1'b1, 4'd6, 32'h0000_000F, 32'hFFFF_FFFF, 1'b1, 8'hF0);
        drive("R7 tst imm sx", 1'b1, 4'd6, 32'h8000_0000, 32'h0, 1'b1, 8'h80);

        drive("R8 pl zero", 1'b1, 4'd7, 32'h0, 32'h0, 1'b0, 8'h0);
        drive("R8 pz zero", 1'b1, 4'd8, 32'h0, 32'h0, 1'b0, 8'h0);
        drive("R8 pl neg",  1'b1, 4'd7, 32'h8000_0001, 32'h0, 1'b0, 8'h0);
        drive("R8 pl pos",  1'b1, 4'd7, 32'h0000_0005, 32'h0, 1'b0, 8'h0);
        drive("R8 pz neg",  1'b1, 4'd8, 32'hFFFF_FFFF, 32'h0, 1'b0, 8'h0);

        drive("R9 dt to zero", 1'b1, 4'd9, 32'h1, 32'h0, 1'b0, 8'h0);
        drive("R9 dt wrap",    1'b1, 4'd9, 32'h0, 32'h0, 1'b0, 8'h0);
        drive("R9 dt mid",     1'b1, 4'd9, 32'h100, 32'h0, 1'b0, 8'h0);
        drive("R13 dt idle",   1'b0, 4'd9, 32'h100, 32'h0, 1'b0, 8'h0);

        drive("R10 div0s mixed", 1'b1, 4'd10, 32'h8000_0000, 32'h0000_0001, 1'b0, 8'h0);
        drive("R2 mq hold",      1'b1, 4'd12, 32'h0, 32'h0, 1'b0, 8'h0);
        drive("R10 div0s both",  1'b1, 4'd10, 32'hF000_0000, 32'h8000_0000, 1'b0, 8'h0);
        drive("R10 div0s q",     1'b1, 4'd10, 32'h0000_0003, 32'h8000_0000, 1'b0, 8'h0);
        drive("R2 reserved 14",  1'b1, 4'd14, 32'h1, 32'h1, 1'b0, 8'h0);
        drive("R2 reserved 15",  1'b1, 4'd15, 32'h0, 32'h0, 1'b0, 8'h0);
        drive("R11 div0u",       1'b1, 4'd11, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 8'h0);

        for (int i = 0; i < 6; i++)
            drive("R2 idle sweep", 1'b0, 4'(i), 32'hA5A5_0000 + 32'(i), 32'hA5A5_0000 + 32'(i), 1'b0, 8'h0);

        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule